// File: doc/BRIEF.md
# Intercept Substitution Slot Receiver

This block sits behind a time-division-multiplexed serial link from an external DSP. It picks substitution audio for two intercepted streams, playback and capture, out of the frame. A deserializer that is not part of the block turns the serial bits into one 16-bit word per slot. It presents each word with a single-cycle strobe and the slot number, and it pulses a frame-end marker after the last slot. Slot 0 of every frame is a control word that carries one valid flag per stream.

A stream's samples are taken only when three conditions hold: its valid flag is set, intercept is enabled for that stream, and the block asked for data at the end of the previous frame. The request is made when intercept is enabled and the buffer has room. It is latched on the frame-end marker, so a request raised during a frame cannot admit data in that same frame. Accepted left/right pairs go into one four-pair buffer per stream, and the consumer drains that buffer through a pop input and show-ahead outputs.

A modem-mode input takes slot 2 away from capture and makes capture mono from slot 3. A rate-lock input, used when capture and playback run at the same rate, makes the playback flag govern the capture slots as well.

Top module: `subst_slot_rx`

## Requirements
- R1: Slot 0 is the control word. Bit 0 is the playback valid flag and bit 1 is the capture valid flag, and the capture flag never admits playback slots. The flags apply to the slots of the same frame and are cleared by the frame-end pulse.
- R2: When playback is admitted, slot 4 gives the right sample and slot 5 the left sample. The pair enters the playback buffer in the cycle after the slot 5 strobe.
- R3: With modem mode off and capture admitted, slot 2 gives the right sample and slot 3 the left sample. The pair is committed on the slot 3 strobe.
- R4: With modem mode on, the slot 3 word is written to both the left and right capture sample, and slot 2 has no effect.
- R5: When the governing valid flag of a frame is 0, that frame's slots for the stream leave the buffer count unchanged.
- R6: A request output is high when intercept is enabled for the stream and its buffer is not full. The request is latched at each frame-end pulse, and only the latched value (0 after reset) can admit data.
- R7: Each buffer holds four pairs. A pair arriving while the buffer is full is dropped and sets that stream's overflow flag, which stays set until reset.
- R8: With rate lock on, the playback valid flag replaces the capture valid flag in qualifying the capture slots. Capture enable and the latched capture request still apply.
- R9: Each buffer shows its oldest pair at its outputs, a pop removes it, a pop on an empty buffer does nothing, and reset leaves both buffers empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_stb | input | 1 | One-cycle strobe: a slot word is present |
| slot_idx | input | 4 | Slot number of the present word |
| slot_data | input | 16 | Slot word |
| frame_end | input | 1 | One-cycle pulse after the last slot of a frame |
| play_icpt_en | input | 1 | Intercept enable for playback |
| cap_icpt_en | input | 1 | Intercept enable for capture |
| modem_mode | input | 1 | Capture is mono from slot 3 |
| rate_lock | input | 1 | Playback flag qualifies capture slots |
| play_pop | input | 1 | Remove oldest playback pair |
| cap_pop | input | 1 | Remove oldest capture pair |
| play_req | output | 1 | Playback request (enabled and not full) |
| cap_req | output | 1 | Capture request (enabled and not full) |
| play_left | output | 16 | Oldest playback left sample |
| play_right | output | 16 | Oldest playback right sample |
| cap_left | output | 16 | Oldest capture left sample |
| cap_right | output | 16 | Oldest capture right sample |
| play_count | output | 3 | Pairs held in playback buffer |
| cap_count | output | 3 | Pairs held in capture buffer |
| play_ovf | output | 1 | Sticky playback overflow |
| cap_ovf | output | 1 | Sticky capture overflow |

## Verification
The first frame after intercept is enabled carries a set flag but must be refused, which separates the latched request from the live one. Frames follow that have the playback flag, only the capture flag, or no flag, and they show that each flag governs only its own slots. The same slot 2/3 words are sent with modem mode off, with modem mode on (distinct words in slot 2 and slot 3 expose whether slot 2 is ignored and slot 3 is duplicated), and with rate lock on, where the capture flag alone must admit nothing. A fill to four pairs, a refused frame while full, and then a frame that repeats the playback slots separate the request-based refusal from an overflow drop, and the pops that follow confirm the order.

// File: rtl/subst_pkg.sv
package subst_pkg;

    localparam int SAMPLE_W    = 16;
    localparam int NUM_STREAMS = 2;
    localparam int IDX_PLAY    = 0;
    localparam int IDX_CAP     = 1;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [3:0]          slot_idx_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } pair_t;

    localparam slot_idx_t SLOT_CTRL   = 4'd0;
    localparam slot_idx_t SLOT_CAP_R  = 4'd2;
    localparam slot_idx_t SLOT_CAP_L  = 4'd3;
    localparam slot_idx_t SLOT_PLAY_R = 4'd4;
    localparam slot_idx_t SLOT_PLAY_L = 4'd5;

    localparam int CTRL_PLAY_BIT = 0;
    localparam int CTRL_CAP_BIT  = 1;

    typedef enum logic [2:0] {
        ROLE_NONE,
        ROLE_CTRL,
        ROLE_CAP_R,
        ROLE_CAP_L,
        ROLE_PLAY_R,
        ROLE_PLAY_L
    } slot_role_e;

    function automatic slot_role_e slot_role(input slot_idx_t idx);
        case (idx)
            SLOT_CTRL:   return ROLE_CTRL;
            SLOT_CAP_R:  return ROLE_CAP_R;
            SLOT_CAP_L:  return ROLE_CAP_L;
            SLOT_PLAY_R: return ROLE_PLAY_R;
            SLOT_PLAY_L: return ROLE_PLAY_L;
            default:     return ROLE_NONE;
        endcase
    endfunction

    function automatic pair_t make_pair(input sample_t l, input sample_t r);
        pair_t p;
        p.left  = l;
        p.right = r;
        return p;
    endfunction

endpackage

// File: rtl/subst_req_latch.sv
module subst_req_latch
    import subst_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   frame_end,
    input  logic [NUM_STREAMS-1:0] icpt_en,
    input  logic [NUM_STREAMS-1:0] buf_full,
    output logic [NUM_STREAMS-1:0] req_now,
    output logic [NUM_STREAMS-1:0] req_q
);

    always_comb begin
        req_now = icpt_en & ~buf_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (frame_end) begin
            req_q <= req_now;
        end
    end

    AST_REQ_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(req_q)); // R6

    AST_REQ_TAKEN_AT_END: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (req_q == $past(req_now))); // R6

endmodule

// File: rtl/subst_slot_decode.sv
module subst_slot_decode
    import subst_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   slot_stb,
    input  slot_idx_t              slot_idx,
    input  sample_t                slot_data,
    input  logic                   frame_end,
    input  logic                   modem_mode,
    input  logic                   rate_lock,
    input  logic [NUM_STREAMS-1:0] icpt_en,
    input  logic [NUM_STREAMS-1:0] req_q,
    output logic [NUM_STREAMS-1:0] push,
    output pair_t [NUM_STREAMS-1:0] push_pair
);

    logic                   flag_play_q;
    logic                   flag_cap_q;
    sample_t                pend_right_q [NUM_STREAMS];
    slot_role_e             role;
    logic [NUM_STREAMS-1:0] qual;

    always_comb begin
        role = slot_stb ? slot_role(slot_idx) : ROLE_NONE;
    end

    // control flags and held right samples
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_play_q <= 1'b0;
            flag_cap_q  <= 1'b0;
            for (int s = 0; s < NUM_STREAMS; s++) begin
                pend_right_q[s] <= '0;
            end
        end else begin
            if (frame_end) begin
                flag_play_q <= 1'b0;
                flag_cap_q  <= 1'b0;
            end
            case (role)
                ROLE_CTRL: begin
                    flag_play_q <= slot_data[CTRL_PLAY_BIT];
                    flag_cap_q  <= slot_data[CTRL_CAP_BIT];
                    for (int s = 0; s < NUM_STREAMS; s++) begin
                        pend_right_q[s] <= '0;
                    end
                end
                ROLE_CAP_R: begin
                    if (!modem_mode) begin
                        pend_right_q[IDX_CAP] <= slot_data;
                    end
                end
                ROLE_PLAY_R: begin
                    pend_right_q[IDX_PLAY] <= slot_data;
                end
                default: ;
            endcase
        end
    end

    // acceptance gating
    always_comb begin
        qual[IDX_PLAY] = flag_play_q & icpt_en[IDX_PLAY] & req_q[IDX_PLAY];
        qual[IDX_CAP]  = (rate_lock ? flag_play_q : flag_cap_q)
                         & icpt_en[IDX_CAP] & req_q[IDX_CAP];
    end

    // pair commit on the later slot of each pair
    always_comb begin
        push[IDX_PLAY]      = (role == ROLE_PLAY_L) && qual[IDX_PLAY];
        push_pair[IDX_PLAY] = make_pair(slot_data, pend_right_q[IDX_PLAY]);
        push[IDX_CAP]       = (role == ROLE_CAP_L) && qual[IDX_CAP];
        if (modem_mode) begin
            push_pair[IDX_CAP] = make_pair(slot_data, slot_data);
        end else begin
            push_pair[IDX_CAP] = make_pair(slot_data, pend_right_q[IDX_CAP]);
        end
    end

    AST_PLAY_PUSH_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        push[IDX_PLAY] |-> (req_q[IDX_PLAY] && icpt_en[IDX_PLAY])); // R6

    AST_CAP_PUSH_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        push[IDX_CAP] |-> (req_q[IDX_CAP] && icpt_en[IDX_CAP])); // R6

    AST_MODEM_MONO: assert property (@(posedge clk) disable iff (rst)
        (push[IDX_CAP] && modem_mode) |->
        (push_pair[IDX_CAP].left == push_pair[IDX_CAP].right)); // R4

    AST_PLAY_ON_LEFT_SLOT: assert property (@(posedge clk) disable iff (rst)
        push[IDX_PLAY] |-> (slot_stb && slot_idx == SLOT_PLAY_L)); // R2

    AST_CAP_ON_LEFT_SLOT: assert property (@(posedge clk) disable iff (rst)
        push[IDX_CAP] |-> (slot_stb && slot_idx == SLOT_CAP_L)); // R3

endmodule

// File: rtl/subst_pair_fifo.sv
module subst_pair_fifo
    import subst_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  pair_t            wr_pair,
    input  logic             pop,
    output pair_t            head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             ovf
);

    pair_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             empty;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        empty   = (count == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        head    = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= wr_pair;
                wr_ptr      <= ptr_next(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            if (do_push && !do_pop) begin
                count <= count + 1'b1;
            end else if (do_pop && !do_push) begin
                count <= count - 1'b1;
            end
            if (push && full) begin
                ovf <= 1'b1;
            end
        end
    end

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf); // R7

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> $stable(count)); // R7

    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (count == '0)); // R9

endmodule

// File: rtl/subst_slot_rx.sv
module subst_slot_rx
    import subst_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_stb,
    input  logic [3:0]       slot_idx,
    input  logic [15:0]      slot_data,
    input  logic             frame_end,
    input  logic             play_icpt_en,
    input  logic             cap_icpt_en,
    input  logic             modem_mode,
    input  logic             rate_lock,
    input  logic             play_pop,
    input  logic             cap_pop,
    output logic             play_req,
    output logic             cap_req,
    output logic [15:0]      play_left,
    output logic [15:0]      play_right,
    output logic [15:0]      cap_left,
    output logic [15:0]      cap_right,
    output logic [CNT_W-1:0] play_count,
    output logic [CNT_W-1:0] cap_count,
    output logic             play_ovf,
    output logic             cap_ovf
);

    logic [NUM_STREAMS-1:0]  icpt_en;
    logic [NUM_STREAMS-1:0]  buf_full;
    logic [NUM_STREAMS-1:0]  req_now;
    logic [NUM_STREAMS-1:0]  req_q;
    logic [NUM_STREAMS-1:0]  push;
    logic [NUM_STREAMS-1:0]  pop;
    logic [NUM_STREAMS-1:0]  ovf;
    pair_t [NUM_STREAMS-1:0] push_pair;
    pair_t [NUM_STREAMS-1:0] head;
    logic [CNT_W-1:0]        count [NUM_STREAMS];

    always_comb begin
        icpt_en[IDX_PLAY] = play_icpt_en;
        icpt_en[IDX_CAP]  = cap_icpt_en;
        pop[IDX_PLAY]     = play_pop;
        pop[IDX_CAP]      = cap_pop;
    end

    subst_req_latch u_req (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .icpt_en   (icpt_en),
        .buf_full  (buf_full),
        .req_now   (req_now),
        .req_q     (req_q)
    );

    subst_slot_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .slot_stb   (slot_stb),
        .slot_idx   (slot_idx),
        .slot_data  (slot_data),
        .frame_end  (frame_end),
        .modem_mode (modem_mode),
        .rate_lock  (rate_lock),
        .icpt_en    (icpt_en),
        .req_q      (req_q),
        .push       (push),
        .push_pair  (push_pair)
    );

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_buf
        subst_pair_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk     (clk),
            .rst     (rst),
            .push    (push[g]),
            .wr_pair (push_pair[g]),
            .pop     (pop[g]),
            .head    (head[g]),
            .count   (count[g]),
            .full    (buf_full[g]),
            .ovf     (ovf[g])
        );
    end

    always_comb begin
        play_req   = req_now[IDX_PLAY];
        cap_req    = req_now[IDX_CAP];
        play_left  = head[IDX_PLAY].left;
        play_right = head[IDX_PLAY].right;
        cap_left   = head[IDX_CAP].left;
        cap_right  = head[IDX_CAP].right;
        play_count = count[IDX_PLAY];
        cap_count  = count[IDX_CAP];
        play_ovf   = ovf[IDX_PLAY];
        cap_ovf    = ovf[IDX_CAP];
    end

    AST_REQ_LOW_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (play_count == CNT_W'(DEPTH)) |-> !play_req); // R6

endmodule

// File: tb/subst_slot_rx_tb.sv
`timescale 1ns/1ps
module subst_slot_rx_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slot_stb = 1'b0;
    logic [3:0]  slot_idx = '0;
    logic [15:0] slot_data = '0;
    logic        frame_end = 1'b0;
    logic        play_icpt_en = 1'b0;
    logic        cap_icpt_en = 1'b0;
    logic        modem_mode = 1'b0;
    logic        rate_lock = 1'b0;
    logic        play_pop = 1'b0;
    logic        cap_pop = 1'b0;
    logic        play_req, cap_req, play_ovf, cap_ovf;
    logic [15:0] play_left, play_right, cap_left, cap_right;
    logic [2:0]  play_count, cap_count;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    subst_slot_rx u_dut (
        .clk(clk), .rst(rst), .slot_stb(slot_stb), .slot_idx(slot_idx),
        .slot_data(slot_data), .frame_end(frame_end),
        .play_icpt_en(play_icpt_en), .cap_icpt_en(cap_icpt_en),
        .modem_mode(modem_mode), .rate_lock(rate_lock),
        .play_pop(play_pop), .cap_pop(cap_pop),
        .play_req(play_req), .cap_req(cap_req),
        .play_left(play_left), .play_right(play_right),
        .cap_left(cap_left), .cap_right(cap_right),
        .play_count(play_count), .cap_count(cap_count),
        .play_ovf(play_ovf), .cap_ovf(cap_ovf)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_slot(input logic [3:0] idx, input logic [15:0] data);
        @(negedge clk);
        slot_stb = 1'b1; slot_idx = idx; slot_data = data;
        @(negedge clk);
        slot_stb = 1'b0;
    endtask

    task automatic end_frame();
        @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    task automatic pop_play();
        @(negedge clk); play_pop = 1'b1;
        @(negedge clk); play_pop = 1'b0;
    endtask

    task automatic pop_cap();
        @(negedge clk); cap_pop = 1'b1;
        @(negedge clk); cap_pop = 1'b0;
    endtask

    task automatic play_frame(input logic [15:0] ctrl, input logic [15:0] r, input logic [15:0] l);
        send_slot(4'd0, ctrl);
        send_slot(4'd4, r);
        send_slot(4'd5, l);
    endtask

    task automatic cap_frame(input logic [15:0] ctrl, input logic [15:0] r, input logic [15:0] l);
        send_slot(4'd0, ctrl);
        send_slot(4'd2, r);
        send_slot(4'd3, l);
    endtask

    task automatic t_reset();
        check("R9 reset play_count", 32'(play_count), 0);
        check("R9 reset cap_count", 32'(cap_count), 0);
        check("R7 reset ovf", {30'd0, play_ovf, cap_ovf}, 0);
        check("R6 req low while disabled", {30'd0, play_req, cap_req}, 0);
    endtask

    task automatic t_gate();
        play_icpt_en = 1'b1;
        @(negedge clk);
        check("R6 live play_req", 32'(play_req), 1);
        play_frame(16'h0001, 16'h1111, 16'h2222);
        check("R6 no latched request, refused", 32'(play_count), 0);
        end_frame();
    endtask

    task automatic t_play();
        play_frame(16'h0001, 16'h0A01, 16'h0B01);
        check("R2 play count", 32'(play_count), 1);
        check("R2 play left slot5", 32'(play_left), 32'h0B01);
        check("R2 play right slot4", 32'(play_right), 32'h0A01);
        end_frame();
    endtask

    task automatic t_clear();
        play_frame(16'h0000, 16'h0C01, 16'h0D01);
        check("R5 flag clear discards", 32'(play_count), 1);
        end_frame();
        play_frame(16'h0002, 16'h0C02, 16'h0D02);
        check("R1 cap flag no play effect", 32'(play_count), 1);
        end_frame();
    endtask

    task automatic t_pop();
        pop_play();
        check("R9 pop removes", 32'(play_count), 0);
        pop_play();
        check("R9 pop on empty ignored", 32'(play_count), 0);
        end_frame();
    endtask

    task automatic t_cap();
        cap_icpt_en = 1'b1;
        end_frame();
        cap_frame(16'h0002, 16'h3301, 16'h4401);
        check("R3 cap count", 32'(cap_count), 1);
        check("R3 cap left slot3", 32'(cap_left), 32'h4401);
        check("R3 cap right slot2", 32'(cap_right), 32'h3301);
        check("R1 play flag clear", 32'(play_count), 0);
        end_frame();
        pop_cap();
    endtask

    task automatic t_modem();
        modem_mode = 1'b1;
        cap_frame(16'h0002, 16'hAAAA, 16'h5555);
        check("R4 modem count", 32'(cap_count), 1);
        check("R4 modem left", 32'(cap_left), 32'h5555);
        check("R4 modem right dup", 32'(cap_right), 32'h5555);
        end_frame();
        modem_mode = 1'b0;
        pop_cap();
    endtask

    task automatic t_rate();
        rate_lock = 1'b1;
        send_slot(4'd0, 16'h0001);
        send_slot(4'd2, 16'h6601);
        send_slot(4'd3, 16'h7701);
        send_slot(4'd4, 16'h8801);
        send_slot(4'd5, 16'h9901);
        check("R8 play flag admits capture", 32'(cap_count), 1);
        check("R8 cap left", 32'(cap_left), 32'h7701);
        check("R8 cap right", 32'(cap_right), 32'h6601);
        check("R8 play also taken", 32'(play_count), 1);
        end_frame();
        cap_frame(16'h0002, 16'h6602, 16'h7702);
        check("R8 cap flag ignored under lock", 32'(cap_count), 1);
        end_frame();
        rate_lock = 1'b0;
        pop_cap();
        pop_play();
        end_frame();
    endtask

    task automatic t_overflow();
        for (int i = 1; i <= 4; i++) begin
            play_frame(16'h0001, 16'h1000 + 16'(i), 16'h2000 + 16'(i));
            end_frame();
        end
        check("R7 four pairs held", 32'(play_count), 4);
        check("R6 req low when full", 32'(play_req), 0);
        play_frame(16'h0001, 16'h1005, 16'h2005);
        check("R6 refused while full", 32'(play_count), 4);
        check("R7 no ovf from refusal", 32'(play_ovf), 0);
        end_frame();
        pop_play();
        check("R9 head after pop", 32'(play_left), 32'h2002);
        end_frame();
        play_frame(16'h0001, 16'h1006, 16'h2006);
        send_slot(4'd4, 16'h1007);
        send_slot(4'd5, 16'h2007);
        check("R7 count at limit", 32'(play_count), 4);
        check("R7 ovf set", 32'(play_ovf), 1);
        check("R7 cap ovf clear", 32'(cap_ovf), 0);
        end_frame();
        for (int k = 0; k < 4; k++) begin
            logic [15:0] exp_l;
            exp_l = (k < 3) ? 16'h2003 + 16'(k) - 16'h0001 + 16'h0001 : 16'h2006;
            if (k < 3) exp_l = 16'h2002 + 16'(k);
            check("R7 order after drop", 32'(play_left), 32'(exp_l));
            pop_play();
        end
        check("R7 drained", 32'(play_count), 0);
        check("R7 ovf sticky", 32'(play_ovf), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_gate();
        t_play();
        t_clear();
        t_pop();
        t_cap();
        t_modem();
        t_rate();
        t_overflow();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule